// File: doc/BRIEF.md
# DSP Modulo Address Generator

This block produces the next value of a data-bus address pointer for a DSP load/store unit. Each access supplies the current pointer, an update mode (keep, step by access size, or add an index), an index value, an access size and a bus select (X or Y). The block returns the updated pointer one clock later.

A configuration register holds a 16-bit lower bound and a 16-bit upper bound for a circular buffer. A separate pair of enable bits turns circular mode on for the X bus, the Y bus, or both. When circular mode applies to an access, the block compares the low half of the pointer before the update with the upper bound. On an exact match, the low half of the new pointer is the lower bound and the high half is kept. An add that steps over the upper bound does not wrap. The keep mode never wraps.

Bit 0 of every address quantity is treated as zero.

Top module: `dsp_modulo_agu`

## Requirements
- R1: After reset, `upd_vld` and `upd_ptr` are 0, both bounds are 0 and circular mode is off on both buses. A step from pointer 0 therefore gives 2 and does not wrap.
- R2: A configuration write with `cfg_sel`=0 loads the upper bound from `cfg_wdata[31:16]` and the lower bound from `cfg_wdata[15:0]`. A write with `cfg_sel`=1 loads the X enable from `cfg_wdata[0]` and the Y enable from `cfg_wdata[1]`. Writes take effect for accesses presented from the next cycle on.
- R3: `acc_mode` 1 (step) adds 2 when `acc_size`=0 and 4 when `acc_size`=1. `acc_mode` 2 (index) adds `acc_idx`. When no wrap occurs, both adds are carried across the full 32-bit pointer.
- R4: With bounds 7000/7004 (hex) and word steps, a pointer of A5007000 runs A5007002, A5007004, A5007000, A5007002. The upper 16 bits stay unchanged through the wrap.
- R5: A wrap happens only for the bus whose enable is set: `acc_bus`=0 is X and `acc_bus`=1 is Y. An access on the other bus steps normally.
- R6: When both enables are set, only X-bus accesses wrap. Y-bus accesses step normally.
- R7: `acc_mode` 0 (keep), and the unused code 3, return the pointer unchanged (with bit 0 cleared). They never wrap, even when the pointer equals the upper bound.
- R8: In index mode, the block wraps when the pre-update pointer equals the upper bound. A sum that passes the upper bound without the pointer equalling it is returned unwrapped.
- R9: Bit 0 of `acc_ptr`, `acc_idx` and both bounds is treated as 0, and `upd_ptr[0]` is always 0.
- R10: `upd_vld` is high exactly in the cycle after an access with `acc_vld`=1. In cycles without an access, `upd_ptr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: bounds register, 1: enable bits |
| cfg_wdata | input | 32 | Configuration write data |
| acc_vld | input | 1 | Access present this cycle |
| acc_bus | input | 1 | 0: X bus, 1: Y bus |
| acc_mode | input | 2 | 0 keep, 1 step, 2 index add |
| acc_size | input | 1 | Step size: 0 → 2, 1 → 4 |
| acc_ptr | input | 32 | Pointer before update |
| acc_idx | input | 32 | Index value for mode 2 |
| upd_vld | output | 1 | Updated pointer valid |
| upd_ptr | output | 32 | Updated pointer |

## Verification
Every updated pointer is due exactly one clock after its access is presented. A configuration write changes the result of accesses presented from the following cycle onward. Each access the driver issues is queued together with its expected pointer and the cycle number in which it must appear. The monitor samples on the falling edge and checks both the value and that cycle number. During idle cycles the bench confirms that the valid flag is low and that the pointer does not move.

// File: rtl/modagu_pkg.sv
package modagu_pkg;
    parameter int AW   = 32;
    parameter int MW   = 16;
    parameter int NBUS = 2;
    localparam int BW  = (NBUS > 1) ? $clog2(NBUS) : 1;

    typedef enum logic [1:0] {
        AM_HOLD = 2'd0,
        AM_INC  = 2'd1,
        AM_IDX  = 2'd2
    } amode_e;

    typedef struct packed {
        logic [MW-1:0]   lim;
        logic [MW-1:0]   base;
        logic [NBUS-1:0] en;
    } modcfg_t;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ptr;
    } upd_t;
endpackage

// File: rtl/modagu_cfg.sv
module modagu_cfg
    import modagu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic [AW-1:0] wdata,
    output modcfg_t       cfg
);
    modcfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (!sel) begin
                cfg_d.lim  = wdata[2*MW-1:MW];
                cfg_d.base = wdata[MW-1:0];
            end else begin
                cfg_d.en = wdata[NBUS-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/modagu_next.sv
module modagu_next
    import modagu_pkg::*;
(
    input  modcfg_t       cfg,
    input  logic [BW-1:0] bus,
    input  amode_e        mode,
    input  logic          size,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] nxt,
    output logic          wrap
);
    logic [NBUS-1:0] en_eff;

    // lowest-numbered enabled bus wins
    for (genvar g = 0; g < NBUS; g++) begin : g_prio
        if (g == 0) begin : g_first
            assign en_eff[g] = cfg.en[g];
        end else begin : g_rest
            assign en_eff[g] = cfg.en[g] & ~(|cfg.en[g-1:0]);
        end
    end

    logic [AW-1:0] p_clr, i_clr, step_d, sum_d;
    logic [MW-1:0] lim_clr, base_clr;

    always_comb begin
        p_clr    = {ptr[AW-1:1], 1'b0};
        i_clr    = {idx[AW-1:1], 1'b0};
        lim_clr  = {cfg.lim[MW-1:1], 1'b0};
        base_clr = {cfg.base[MW-1:1], 1'b0};
        case (mode)
            AM_INC:  step_d = AW'(2) << size;
            AM_IDX:  step_d = i_clr;
            default: step_d = '0;
        endcase
        sum_d = p_clr + step_d;
        wrap  = ((mode == AM_INC) || (mode == AM_IDX)) && en_eff[bus]
                && (p_clr[MW-1:0] == lim_clr);
        nxt   = wrap ? {p_clr[AW-1:MW], base_clr} : sum_d;
    end
endmodule

// File: rtl/dsp_modulo_agu.sv
module dsp_modulo_agu
    import modagu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        acc_vld,
    input  logic        acc_bus,
    input  logic [1:0]  acc_mode,
    input  logic        acc_size,
    input  logic [31:0] acc_ptr,
    input  logic [31:0] acc_idx,
    output logic        upd_vld,
    output logic [31:0] upd_ptr
);
    modcfg_t       cfg;
    logic [AW-1:0] nxt;
    logic          wrap;
    upd_t          res_d, res_q;

    modagu_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    modagu_next u_next (
        .cfg  (cfg),
        .bus  (acc_bus),
        .mode (amode_e'(acc_mode)),
        .size (acc_size),
        .ptr  (acc_ptr),
        .idx  (acc_idx),
        .nxt  (nxt),
        .wrap (wrap)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = acc_vld;
        if (acc_vld) res_d.ptr = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign upd_vld = res_q.vld;
    assign upd_ptr = res_q.ptr;

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |=> upd_vld);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> (!upd_vld && $stable(upd_ptr)));

    // R9
    lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |-> !upd_ptr[0]);

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (acc_mode == 2'd0)) |=> (upd_ptr == {$past(acc_ptr[AW-1:1]), 1'b0}));

    // R4
    wrap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && wrap) |=> (upd_ptr[AW-1:MW] == $past(acc_ptr[AW-1:MW])));

    // R6
    x_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && wrap && acc_bus) |-> !cfg.en[0]);
endmodule

// File: tb/sim_dsp_modulo_agu.sv
module sim_dsp_modulo_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_vld = 1'b0, acc_bus = 1'b0, acc_size = 1'b0;
    logic [1:0]  acc_mode = 2'd0;
    logic [31:0] acc_ptr = '0, acc_idx = '0;
    logic        upd_vld;
    logic [31:0] upd_ptr;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsp_modulo_agu u0 (.*);

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic acc(input bit bus, input logic [1:0] mode, input bit size,
                       input logic [31:0] ptr, input logic [31:0] idx,
                       input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_vld = 1'b1; acc_bus = bus; acc_mode = mode; acc_size = size;
        acc_ptr = ptr; acc_idx = idx;
        exp_q.push_back(exp); due_q.push_back(cyc + 1); tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_vld = 1'b0;
    endtask

    // monitor: compare each result in the cycle it is due
    always @(negedge clk) begin
        if (rst_n && upd_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", upd_ptr, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic int          d = due_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check(upd_ptr === e, t, upd_ptr, e);
                check(d == cyc, "R10 latency", 32'(cyc), 32'(d));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(upd_vld === 1'b0, "R1 reset vld", 32'(upd_vld), 32'h0);
        check(upd_ptr === 32'h0, "R1 reset ptr", upd_ptr, 32'h0);
        rst_n = 1'b1;

        acc(0, 2'd1, 0, 32'h0000_0000, 0, 32'h0000_0002, "R1 modulo off");
        acc(0, 2'd1, 0, 32'h1234_5678, 0, 32'h1234_567A, "R3 word step");
        acc(0, 2'd1, 1, 32'h1234_5678, 0, 32'h1234_567C, "R3 long step");
        acc(0, 2'd1, 0, 32'h0000_FFFE, 0, 32'h0001_0000, "R3 carry");
        acc(1, 2'd2, 0, 32'h0000_0100, 32'h0001_0000, 32'h0001_0100, "R3 index add");
        idle();

        wr_cfg(0, 32'h7004_7000);
        wr_cfg(1, 32'h0000_0001);
        acc(0, 2'd1, 0, 32'hA500_7000, 0, 32'hA500_7002, "R4 seq1");
        acc(0, 2'd1, 0, 32'hA500_7002, 0, 32'hA500_7004, "R4 seq2");
        acc(0, 2'd1, 0, 32'hA500_7004, 0, 32'hA500_7000, "R2 R4 wrap");
        acc(0, 2'd1, 0, 32'hA500_7000, 0, 32'hA500_7002, "R4 seq4");
        acc(1, 2'd1, 0, 32'hA500_7004, 0, 32'hA500_7006, "R5 Y off");
        acc(0, 2'd0, 0, 32'hA500_7004, 0, 32'hA500_7004, "R7 keep no wrap");
        acc(0, 2'd3, 0, 32'hA500_7004, 0, 32'hA500_7004, "R7 code3");
        acc(0, 2'd2, 0, 32'hA500_7002, 32'h4, 32'hA500_7006, "R8 overshoot");
        acc(0, 2'd2, 0, 32'hA500_7004, 32'h8, 32'hA500_7000, "R8 index wrap");
        acc(0, 2'd1, 0, 32'hA500_7005, 0, 32'hA500_7000, "R9 ptr lsb");
        acc(1, 2'd2, 0, 32'h0000_0100, 32'h3, 32'h0000_0102, "R9 idx lsb");
        idle();

        wr_cfg(0, 32'h7005_7001);
        acc(0, 2'd1, 0, 32'h0000_7004, 0, 32'h0000_7000, "R9 bound lsb");
        idle();

        wr_cfg(0, 32'h7004_7000);
        wr_cfg(1, 32'h0000_0002);
        acc(1, 2'd1, 0, 32'h0000_7004, 0, 32'h0000_7000, "R5 Y wraps");
        acc(0, 2'd1, 0, 32'h0000_7004, 0, 32'h0000_7006, "R5 X off");
        idle();

        wr_cfg(1, 32'h0000_0003);
        acc(0, 2'd1, 0, 32'h0000_7004, 0, 32'h0000_7000, "R6 X wraps");
        acc(1, 2'd1, 0, 32'h0000_7004, 0, 32'h0000_7006, "R6 Y steps");
        idle();

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R10 drained", 32'(exp_q.size()), 32'h0);
        begin
            automatic logic [31:0] held = upd_ptr;
            @(negedge clk);
            check(upd_vld === 1'b0, "R10 idle vld", 32'(upd_vld), 32'h0);
            check(upd_ptr === held, "R10 idle hold", upd_ptr, held);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule